// File: doc/BRIEF.md
# Indirect Register Access Controller

This block is a register-bus slave that gives software a two-word window into internal tables that have no direct address mapping. One word is a control word and the other is a data word. Software writes the control word with a bank selector, an entry offset, a direction bit and the busy bit set. The busy bit stays set while the access runs and drops by itself when the access is complete.

To write an entry, software first loads the data word and then starts a write command. To read an entry, software starts a read command, polls until busy is clear, and then collects the entry from the data word. Bank 0 is implemented here: a per-filter receive DMA channel select table with one narrow entry per address filter. Every other bank selector, and every offset beyond the table, is accepted and completes normally but has no effect on the table. A read of such a location returns zero.

While an access is running, the block accepts no further bus writes to either word. This keeps the selector, offset and write data stable until the access completes.

Top module: `ind_access_ctrl`

## Requirements
- R1: After reset, the control word and the data word read as zero, and every table entry reads back as zero.
- R2: The control word is laid out as follows: bank selector at bits 19:16, entry offset at bits 15:8, auto flag at bit 5, direction at bit 1 (0 = write, 1 = read) and busy at bit 0. All other bits read as zero.
- R3: A control write with bit 0 set, made while idle, sets busy on the next cycle. Busy then stays set for exactly LATENCY cycles before it clears.
- R4: A write command to bank 0 with an offset below ENTRIES stores the low ENTRY_W bits of the data word into that entry when busy clears. No other entry changes.
- R5: A read command to bank 0 with an offset below ENTRIES loads the entry, zero-extended, into the data word in the cycle in which busy clears.
- R6: A control write made while busy is set is ignored. The fields keep their values, and no new access starts.
- R7: A data-word write made while busy is set is ignored, and the running access uses the earlier data.
- R8: A command with a bank selector other than 0, or with an offset of ENTRIES or more, completes with the normal busy timing. A write of this kind changes no entry, and a read of this kind returns zero in the data word.
- R9: A control write with bit 0 clear, made while idle, updates the fields, including the auto flag. It starts no access, and the data word and the table stay unchanged.
- R10: Addresses other than the control offset (0x700) and the data offset (0x704) read as zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wen | input | 1 | Write strobe for the register bus, one cycle per write |
| bus_addr | input | ADDR_W (12) | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from register state |

## Verification
The bench builds the block with its default parameters: a 32-entry table of 10-bit entries and an access latency of 4 cycles. With 32 entries, both table edges (offsets 0 and 31) and the first out-of-range offset (32) can be reached through the 8-bit offset field. The out-of-range case exposes any aliasing that would come from truncating the offset. A latency of 4 leaves a busy window long enough for writes to both words to be placed inside it, so the ignored-write rules can be tested.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int MSEL_LSB = 16;
  localparam int MSEL_W   = 4;
  localparam int AOFF_LSB = 8;
  localparam int AOFF_W   = 8;
  localparam int AUTO_BIT = 5;
  localparam int CMD_BIT  = 1;
  localparam int BUSY_BIT = 0;

  localparam logic [MSEL_W-1:0] BANK_CHSEL = '0;

  typedef enum logic {
    CMD_WR = 1'b0,
    CMD_RD = 1'b1
  } iac_cmd_e;

  typedef struct packed {
    logic [MSEL_W-1:0] msel;
    logic [AOFF_W-1:0] aoff;
    logic              auto_fl;
    iac_cmd_e          cmd;
  } iac_ctrl_t;
endpackage

// File: rtl/iac_rst_sync.sv
module iac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/iac_ctrl_reg.sv
module iac_ctrl_reg
  import iac_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  iac_ctrl_t fields_in,
  input  logic      start_in,
  output iac_ctrl_t ctrl_q,
  output logic      busy,
  output logic      done
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  iac_ctrl_t        ctrl_d;
  logic             ctrl_en, cnt_en;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  // next state: fields load only while idle; counter runs down once started
  always_comb begin
    ctrl_d  = fields_in;
    ctrl_en = wr_en && !busy;
    cnt_en  = busy || (ctrl_en && start_in);
    cnt_d   = busy ? (cnt_q - CNT_W'(1)) : CNT_W'(LATENCY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/iac_chsel_table.sv
module iac_chsel_table #(
  parameter int ENTRIES = 32,
  parameter int ENTRY_W = 10,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [ENTRY_W-1:0]         wdata,
  output logic [ENTRY_W-1:0]         rdata,
  output logic [ENTRIES*ENTRY_W-1:0] flat
);
  logic [ENTRY_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (we && (idx == IDX_W'(i))) mem_q[i] <= wdata;
      end
    end
  end

  assign rdata = mem_q[idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign flat[g*ENTRY_W +: ENTRY_W] = mem_q[g];
  end
endmodule

// File: rtl/ind_access_ctrl.sv
module ind_access_ctrl
  import iac_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CTRL_OFS = 'h700,
  parameter int DATA_OFS = 'h704,
  parameter int ENTRIES  = 32,
  parameter int ENTRY_W  = 10,
  parameter int LATENCY  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int                IDX_W  = $clog2(ENTRIES);
  localparam int                TBL_W  = ENTRIES * ENTRY_W;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

  logic          rst_n_sync;
  logic          ctrl_wr, data_wr, start_bit;
  iac_ctrl_t     fields_in, ctrl_q;
  logic          busy, done, is_rd, hit, tbl_we;
  logic [ENTRY_W-1:0] tbl_rd;
  logic [TBL_W-1:0]   tbl_flat;
  logic [31:0]   data_q, data_d;
  logic          data_en;

  iac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // bus decode and field extraction
  assign ctrl_wr   = bus_wen && (bus_addr == CTRL_A);
  assign data_wr   = bus_wen && (bus_addr == DATA_A);
  assign start_bit = bus_wdata[BUSY_BIT];

  always_comb begin
    fields_in.msel    = bus_wdata[MSEL_LSB +: MSEL_W];
    fields_in.aoff    = bus_wdata[AOFF_LSB +: AOFF_W];
    fields_in.auto_fl = bus_wdata[AUTO_BIT];
    fields_in.cmd     = iac_cmd_e'(bus_wdata[CMD_BIT]);
  end

  iac_ctrl_reg #(.LATENCY(LATENCY)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (ctrl_wr),
    .fields_in (fields_in),
    .start_in  (start_bit),
    .ctrl_q    (ctrl_q),
    .busy      (busy),
    .done      (done)
  );

  // bank decode: only bank 0 with an in-range offset reaches the table
  assign is_rd  = (ctrl_q.cmd == CMD_RD);
  assign hit    = (ctrl_q.msel == BANK_CHSEL) && (32'(ctrl_q.aoff) < ENTRIES);
  assign tbl_we = done && !is_rd && hit;

  iac_chsel_table #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (tbl_we),
    .idx   (ctrl_q.aoff[IDX_W-1:0]),
    .wdata (data_q[ENTRY_W-1:0]),
    .rdata (tbl_rd),
    .flat  (tbl_flat)
  );

  // data word next state
  always_comb begin
    data_d  = data_q;
    data_en = 1'b0;
    if (done && is_rd) begin
      data_en = 1'b1;
      data_d  = hit ? 32'(tbl_rd) : 32'd0;
    end else if (data_wr && !busy) begin
      data_en = 1'b1;
      data_d  = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_A) begin
      bus_rdata[MSEL_LSB +: MSEL_W] = ctrl_q.msel;
      bus_rdata[AOFF_LSB +: AOFF_W] = ctrl_q.aoff;
      bus_rdata[AUTO_BIT]           = ctrl_q.auto_fl;
      bus_rdata[CMD_BIT]            = is_rd;
      bus_rdata[BUSY_BIT]           = busy;
    end else if (bus_addr == DATA_A) begin
      bus_rdata = data_q;
    end
  end
endmodule

// File: rtl/iac_checker.sv
module iac_checker #(
  parameter int LATENCY = 4,
  parameter int TBL_W   = 320
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             start_bit,
  input logic             busy,
  input logic             done,
  input logic             is_rd,
  input logic             hit,
  input logic [13:0]      ctrl_bits,
  input logic [31:0]      data_q,
  input logic [TBL_W-1:0] tbl_flat
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && start_bit && !busy) |=> busy); // R3
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == LATENCY)); // R3
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl_bits)); // R6
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(data_q)); // R7
  AST_TABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && !is_rd && hit) |=> $stable(tbl_flat)); // R8
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_rd && !hit) |=> (data_q == 32'd0)); // R8
endmodule

bind ind_access_ctrl iac_checker #(.LATENCY(LATENCY), .TBL_W(ENTRIES*ENTRY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .ctrl_wr   (ctrl_wr),
  .start_bit (start_bit),
  .busy      (busy),
  .done      (done),
  .is_rd     (is_rd),
  .hit       (hit),
  .ctrl_bits (ctrl_q),
  .data_q    (data_q),
  .tbl_flat  (tbl_flat)
);

// File: tb/sim_ind_access_ctrl.sv
`timescale 1ns/1ps
module sim_ind_access_ctrl;
  localparam int LAT = 4;
  localparam int ENT = 32;
  localparam logic [11:0] A_CTRL = 12'h700;
  localparam logic [11:0] A_DATA = 12'h704;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wen;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  always #4 clk = ~clk;

  ind_access_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";

  // behavioural reference model
  int unsigned m_tbl [ENT];
  int unsigned m_data;
  int m_msel, m_aoff, m_auto, m_cmd, m_busy;
  bit m_hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) m_tbl[i] = 0;
      m_data = 0; m_msel = 0; m_aoff = 0; m_auto = 0; m_cmd = 0; m_busy = 0;
    end else if (m_busy > 0) begin
      if (m_busy == 1) begin
        m_hit = (m_msel == 0) && (m_aoff < ENT);
        if (m_cmd == 0) begin
          if (m_hit) m_tbl[m_aoff] = m_data & 32'h3FF;
        end else begin
          m_data = m_hit ? m_tbl[m_aoff] : 0;
        end
      end
      m_busy = m_busy - 1;
    end else if (bus_wen && bus_addr == A_CTRL) begin
      m_msel = int'(bus_wdata[19:16]);
      m_aoff = int'(bus_wdata[15:8]);
      m_auto = int'(bus_wdata[5]);
      m_cmd  = int'(bus_wdata[1]);
      if (bus_wdata[0]) m_busy = LAT;
    end else if (bus_wen && bus_addr == A_DATA) begin
      m_data = bus_wdata;
    end
  end

  function automatic logic [31:0] model_read(logic [11:0] a);
    if (a == A_CTRL)
      return (32'(m_msel) << 16) | (32'(m_aoff) << 8) | (32'(m_auto) << 5) |
             (32'(m_cmd) << 1) | 32'(m_busy > 0);
    else if (a == A_DATA)
      return m_data;
    else
      return 32'd0;
  endfunction

  function automatic logic [31:0] ctl(int msel, int aoff, int auto_f, int cmd, int go);
    return (32'(msel) << 16) | (32'(aoff) << 8) | (32'(auto_f) << 5) |
           (32'(cmd) << 1) | 32'(go);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(cur_req, bus_rdata, model_read(bus_addr));
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wen = 1'b0;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic xact(int msel, int aoff, int cmd, logic [31:0] d);
    if (cmd == 0) wr(A_DATA, d);
    wr(A_CTRL, ctl(msel, aoff, 0, cmd, 1));
    bus_addr = A_CTRL;
    repeat (LAT) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    cur_req = "R1";
    rd_chk(A_CTRL, 32'd0, "R1");
    rd_chk(A_DATA, 32'd0, "R1");
    xact(0, 31, 1, 0);
    rd_chk(A_DATA, 32'd0, "R1");
    xact(0, 0, 1, 0);
    rd_chk(A_DATA, 32'd0, "R1");

    // R2: field layout, unused bits read zero
    cur_req = "R2";
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd_chk(A_CTRL, 32'h000F_FF22, "R2");
    rd_chk(A_DATA, 32'd0, "R9");

    // R4: writes at both table edges and in the middle
    cur_req = "R4";
    xact(0, 0, 0, 32'hFFFF_F2A5);
    xact(0, 5, 0, 32'h0000_0133);
    xact(0, 31, 0, 32'h0000_03FF);

    // R5: reads return the stored entries zero-extended
    cur_req = "R5";
    xact(0, 5, 1, 0);
    rd_chk(A_DATA, 32'h133, "R5");
    xact(0, 0, 1, 0);
    rd_chk(A_DATA, 32'h2A5, "R5");
    xact(0, 31, 1, 0);
    rd_chk(A_DATA, 32'h3FF, "R5");

    // R3: busy set for exactly LAT cycles
    cur_req = "R3";
    wr(A_CTRL, ctl(0, 5, 0, 1, 1));
    rd_chk(A_CTRL, ctl(0, 5, 0, 1, 1), "R3");
    for (int i = 0; i < LAT - 1; i++) begin
      step();
      check("R3", {31'd0, bus_rdata[0]}, 32'd1);
    end
    step();
    check("R3", {31'd0, bus_rdata[0]}, 32'd0);

    // R6: control write while busy is dropped
    cur_req = "R6";
    wr(A_CTRL, ctl(0, 31, 0, 1, 1));
    wr(A_CTRL, ctl(7, 3, 1, 0, 1));
    bus_addr = A_CTRL;
    repeat (LAT - 1) step();
    rd_chk(A_CTRL, ctl(0, 31, 0, 1, 0), "R6");
    rd_chk(A_DATA, 32'h3FF, "R6");

    // R7: data write while busy is dropped
    cur_req = "R7";
    wr(A_DATA, 32'h0AA);
    wr(A_CTRL, ctl(0, 7, 0, 0, 1));
    wr(A_DATA, 32'h155);
    bus_addr = A_CTRL;
    repeat (LAT - 1) step();
    rd_chk(A_DATA, 32'h0AA, "R7");
    xact(0, 7, 1, 0);
    rd_chk(A_DATA, 32'h0AA, "R7");

    // R8: unimplemented bank and out-of-range offsets
    cur_req = "R8";
    xact(3, 5, 0, 32'h111);
    xact(0, 5, 1, 0);
    rd_chk(A_DATA, 32'h133, "R8");
    wr(A_DATA, 32'hABC);
    xact(3, 5, 1, 0);
    rd_chk(A_DATA, 32'd0, "R8");
    xact(0, 32, 0, 32'h3C3);
    wr(A_DATA, 32'h5A5);
    xact(0, 200, 1, 0);
    rd_chk(A_DATA, 32'd0, "R8");
    xact(0, 0, 1, 0);
    rd_chk(A_DATA, 32'h2A5, "R8");

    // R10: other addresses read zero and are ignored
    cur_req = "R10";
    wr(12'h708, 32'hDEAD_BEEF);
    wr(12'h300, 32'h0000_1234);
    rd_chk(12'h708, 32'd0, "R10");
    rd_chk(A_DATA, 32'h2A5, "R10");
    rd_chk(A_CTRL, ctl(0, 0, 0, 1, 0), "R10");

    // R9: control write without busy bit only updates fields
    cur_req = "R9";
    wr(A_CTRL, ctl(0, 9, 1, 0, 0));
    bus_addr = A_CTRL;
    step(); step();
    rd_chk(A_CTRL, 32'h0000_0920, "R9");
    rd_chk(A_DATA, 32'h2A5, "R9");
    xact(0, 9, 1, 0);
    rd_chk(A_DATA, 32'd0, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule